// File: doc/BRIEF.md
# SIMD Lane Integer ALU

This block is the integer arithmetic and logic unit of one lane in a SIMD add pipeline. A 5-bit opcode selects one operation on two 32-bit operands, A and B. The block returns a 32-bit result, a carry-out and a flag that marks an opcode outside the integer set.

The opcode map is sparse and fixed. One range of opcodes belongs to a floating-point unit elsewhere, and some other codes are unassigned. For those codes this lane returns zero and raises the unsupported flag, so the surrounding pipeline can route the operation to another unit or report a fault. The operations cover add and subtract, three shifts and a rotate, signed min and max, and bitwise logic. There is also a count of leading zeros, and byte-wise saturating add and subtract over four 8-bit elements.

The block is purely combinational. A decoder turns the opcode into a small control word, and the datapath uses that word to compute the result.

Top module: `lane_alu`

## Requirements
- R1: Opcode 0 (no-op) gives result 0, carry 0 and unsupported 0.
- R2: Opcode 12 gives A+B modulo 2^32, with carry equal to bit 32 of the full sum. Opcode 13 gives A-B modulo 2^32, with carry 1 exactly when B is greater than A as unsigned values (a borrow).
- R3: Opcode 14 shifts A right logically, opcode 15 shifts A right arithmetically (sign fill) and opcode 17 shifts A left. The shift amount is B[4:0], and B[31:5] is ignored.
- R4: Opcode 16 rotates A right by B[4:0] bit positions. A rotate by 0 returns A.
- R5: Opcode 18 returns the smaller and opcode 19 the larger of A and B, both compared as signed 32-bit values.
- R6: Opcodes 20, 21 and 22 return A AND B, A OR B and A XOR B. Opcode 23 returns the bitwise inverse of A, and B has no effect on it.
- R7: Opcode 24 returns the number of zero bits above the highest set bit of A. A equal to 0 returns 32.
- R8: Opcode 30 adds each byte k of A (bits 8k+7 down to 8k, k = 0 to 3) to the same byte of B as unsigned values. A byte sum above 255 gives 255.
- R9: Opcode 31 subtracts each byte k of B from the same byte of A as unsigned values. A byte difference below 0 gives 0.
- R10: Opcodes 1 to 11 and 25 to 29 give result 0, carry 0 and unsupported 1. All other opcodes give unsupported 0.
- R11: Carry is 0 for every opcode other than 12 and 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 5 | Operation select |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B, which also holds the shift amount |
| result | output | 32 | Operation result |
| carryOut | output | 1 | Carry of add, or borrow of subtract |
| unsupported | output | 1 | Opcode is not in the integer set |

## Verification
All three outputs depend only on the inputs present in the same cycle, so each result is due zero cycles after its stimulus. The bench applies each opcode and its operands just after a rising clock edge. It samples result, carryOut and unsupported at the following falling edge, after the combinational paths have settled and before the next inputs arrive. Directed vectors cover the boundaries: a zero operand for count-leading-zeros, shift and rotate amounts of 0 and 31 with junk in the upper bits of B, byte saturation at both ends, and the sign edges of min and max. Seeded random vectors then sweep all 32 opcodes.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    opNop  = 5'd0,
    opAdd  = 5'd12,
    opSub  = 5'd13,
    opShr  = 5'd14,
    opAsr  = 5'd15,
    opRor  = 5'd16,
    opShl  = 5'd17,
    opMin  = 5'd18,
    opMax  = 5'd19,
    opAnd  = 5'd20,
    opOr   = 5'd21,
    opXor  = 5'd22,
    opNot  = 5'd23,
    opClz  = 5'd24,
    opVadd = 5'd30,
    opVsub = 5'd31
  } opT;

  typedef enum logic [3:0] {
    selZero, selAdd, selSub, selShr, selAsr, selRor, selShl, selMin,
    selMax, selAnd, selOr, selXor, selNot, selClz, selVadd, selVsub
  } selT;

  typedef struct packed {
    selT  sel;
    logic carryEn;
    logic unsup;
  } ctrlT;
endpackage

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output ctrlT           ctrl
);
  always_comb begin
    ctrl = '{sel: selZero, carryEn: 1'b0, unsup: 1'b0};
    case (opcode)
      opNop:  ctrl.sel = selZero;
      opAdd:  begin ctrl.sel = selAdd; ctrl.carryEn = 1'b1; end
      opSub:  begin ctrl.sel = selSub; ctrl.carryEn = 1'b1; end
      opShr:  ctrl.sel = selShr;
      opAsr:  ctrl.sel = selAsr;
      opRor:  ctrl.sel = selRor;
      opShl:  ctrl.sel = selShl;
      opMin:  ctrl.sel = selMin;
      opMax:  ctrl.sel = selMax;
      opAnd:  ctrl.sel = selAnd;
      opOr:   ctrl.sel = selOr;
      opXor:  ctrl.sel = selXor;
      opNot:  ctrl.sel = selNot;
      opClz:  ctrl.sel = selClz;
      opVadd: ctrl.sel = selVadd;
      opVsub: ctrl.sel = selVsub;
      default: ctrl.unsup = 1'b1;
    endcase
  end
endmodule

// File: rtl/lane_alu_dp.sv
module lane_alu_dp
  import lane_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ELEM  = 8
) (
  input  ctrlT             ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  localparam int SHW   = $clog2(WIDTH);
  localparam int LANES = WIDTH / ELEM;

  logic [SHW-1:0]   shAmt;
  logic [WIDTH:0]   sumFull;
  logic [WIDTH:0]   diffFull;
  logic [2*WIDTH-1:0] rotPair;
  logic [WIDTH-1:0] rotRes;
  logic             aLess;
  logic [SHW:0]     clzCount;
  logic [WIDTH-1:0] vaddRes;
  logic [WIDTH-1:0] vsubRes;

  assign shAmt    = opB[SHW-1:0];
  assign sumFull  = {1'b0, opA} + {1'b0, opB};
  assign diffFull = {1'b0, opA} - {1'b0, opB};
  assign rotPair  = {opA, opA} >> shAmt;
  assign rotRes   = rotPair[WIDTH-1:0];
  assign aLess    = $signed(opA) < $signed(opB);

  always_comb begin
    clzCount = (SHW+1)'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (opA[i]) clzCount = (SHW+1)'(WIDTH - 1 - i);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [ELEM:0] bSum;
    logic [ELEM:0] bDiff;
    assign bSum  = {1'b0, opA[k*ELEM +: ELEM]} + {1'b0, opB[k*ELEM +: ELEM]};
    assign bDiff = {1'b0, opA[k*ELEM +: ELEM]} - {1'b0, opB[k*ELEM +: ELEM]};
    assign vaddRes[k*ELEM +: ELEM] = bSum[ELEM]  ? {ELEM{1'b1}} : bSum[ELEM-1:0];
    assign vsubRes[k*ELEM +: ELEM] = bDiff[ELEM] ? {ELEM{1'b0}} : bDiff[ELEM-1:0];
  end

  always_comb begin
    case (ctrl.sel)
      selAdd:  result = sumFull[WIDTH-1:0];
      selSub:  result = diffFull[WIDTH-1:0];
      selShr:  result = opA >> shAmt;
      selAsr:  result = $unsigned($signed(opA) >>> shAmt);
      selRor:  result = rotRes;
      selShl:  result = opA << shAmt;
      selMin:  result = aLess ? opA : opB;
      selMax:  result = aLess ? opB : opA;
      selAnd:  result = opA & opB;
      selOr:   result = opA | opB;
      selXor:  result = opA ^ opB;
      selNot:  result = ~opA;
      selClz:  result = WIDTH'(clzCount);
      selVadd: result = vaddRes;
      selVsub: result = vsubRes;
      default: result = '0;
    endcase
  end

  always_comb begin
    carryOut = 1'b0;
    if (ctrl.carryEn) carryOut = (ctrl.sel == selAdd) ? sumFull[WIDTH] : diffFull[WIDTH];
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ELEM  = 8
) (
  input  logic [4:0]       opcode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             unsupported
);
  ctrlT ctrl;

  lane_alu_ctrl uCtrl (.opcode(opcode), .ctrl(ctrl));

  lane_alu_dp #(.WIDTH(WIDTH), .ELEM(ELEM)) uDp (
    .ctrl(ctrl), .opA(opA), .opB(opB), .result(result), .carryOut(carryOut)
  );

  assign unsupported = ctrl.unsup;
endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
  parameter int WIDTH = 32,
  parameter int ELEM  = 8
) (
  input logic [4:0]       opcode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             unsupported
);
  localparam int LANES = WIDTH / ELEM;

  always_comb begin
    if (unsupported) begin
      a_r10_unsup_zero: assert (result == '0 && !carryOut)
        else $error("unsupported opcode produced data");
    end
    if (opcode != 5'd12 && opcode != 5'd13) begin
      a_r11_carry_only_addsub: assert (!carryOut)
        else $error("carry outside add/sub");
    end
    if (opcode == 5'd24) begin
      a_r7_clz_range: assert (result <= WIDTH)
        else $error("clz out of range");
    end
    if (opcode == 5'd19) begin
      a_r5_max_ge: assert ((result == opA || result == opB) && $signed(result) >= $signed(opA)
                           && $signed(result) >= $signed(opB))
        else $error("max wrong");
    end
    if (opcode == 5'd0) begin
      a_r1_nop_quiet: assert (result == '0 && !unsupported)
        else $error("nop not quiet");
    end
    for (int k = 0; k < LANES; k++) begin
      if (opcode == 5'd30) begin
        a_r8_vadd_ge: assert (result[k*ELEM +: ELEM] >= opA[k*ELEM +: ELEM])
          else $error("vadd byte below operand");
      end
      if (opcode == 5'd31) begin
        a_r9_vsub_le: assert (result[k*ELEM +: ELEM] <= opA[k*ELEM +: ELEM])
          else $error("vsub byte above operand");
      end
    end
  end
endmodule

bind lane_alu lane_alu_chk #(.WIDTH(WIDTH), .ELEM(ELEM)) uChk (
  .opcode(opcode), .opA(opA), .opB(opB), .result(result),
  .carryOut(carryOut), .unsupported(unsupported)
);

// File: tb/tb_lane_alu.sv
module tb_lane_alu;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic [4:0]  opcode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        carryOut;
  logic        unsupported;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  lane_alu dut (.opcode(opcode), .opA(opA), .opB(opB), .result(result),
                .carryOut(carryOut), .unsupported(unsupported));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0: return "R1";
      5'd12, 5'd13: return "R2";
      5'd14, 5'd15, 5'd17: return "R3";
      5'd16: return "R4";
      5'd18, 5'd19: return "R5";
      5'd20, 5'd21, 5'd22, 5'd23: return "R6";
      5'd24: return "R7";
      5'd30: return "R8";
      5'd31: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [33:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [31:0] r;
    logic c, u;
    int s, n, x;
    longint unsigned wide;
    r = 0; c = 0; u = 0;
    s = int'(b % 32);
    case (op)
      5'd0: r = 0;
      5'd12: begin wide = longint'(a) + longint'(b); r = wide[31:0]; c = wide[32]; end
      5'd13: begin r = a - b; c = (b > a); end
      5'd14: r = a >> s;
      5'd15: begin r = a; for (int i = 0; i < s; i++) r = {r[31], r[31:1]}; end
      5'd16: begin r = a; for (int i = 0; i < s; i++) r = {r[0], r[31:1]}; end
      5'd17: r = a << s;
      5'd18: r = (int'(a) < int'(b)) ? a : b;
      5'd19: r = (int'(a) > int'(b)) ? a : b;
      5'd20: r = a & b;
      5'd21: r = a | b;
      5'd22: r = a ^ b;
      5'd23: r = ~a;
      5'd24: begin n = 0; while (n < 32 && a[31-n] == 1'b0) n++; r = n; end
      5'd30, 5'd31: begin
        for (int k = 0; k < 4; k++) begin
          x = (op == 5'd30) ? int'(a[8*k +: 8]) + int'(b[8*k +: 8])
                            : int'(a[8*k +: 8]) - int'(b[8*k +: 8]);
          if (x > 255) x = 255;
          if (x < 0) x = 0;
          r[8*k +: 8] = 8'(x);
        end
      end
      default: u = 1;
    endcase
    return {u, c, r};
  endfunction

  task automatic check(input string req, input logic [33:0] exp);
    checks++;
    if ({unsupported, carryOut, result} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual u=%b c=%b r=%h expected u=%b c=%b r=%h",
               req, opcode, opA, opB, unsupported, carryOut, result, exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    opcode = op; opA = a; opB = b;
    @(negedge clk);
    check(reqOf(op), model(op, a, b));
  endtask

  task automatic finishUp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES && !done) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, MAX_CYCLES);
        finishUp();
      end
    end
  end

  initial begin
    logic [31:0] notRes;
    void'($urandom(32'd20240611));
    // reset-state / R1: all-zero inputs select no-op
    @(negedge clk);
    check("R1", 34'd0);
    apply(5'd0, 32'hFFFF_FFFF, 32'h1234_5678);                 // R1
    apply(5'd12, 32'hFFFF_FFFF, 32'd1);                         // R2 carry out
    apply(5'd12, 32'h7000_0000, 32'h0FFF_FFFF);                 // R2 no carry
    apply(5'd13, 32'd5, 32'd7);                                 // R2 borrow
    apply(5'd13, 32'd7, 32'd7);                                 // R2 equal, no borrow
    apply(5'd14, 32'h8000_0000, 32'hFFFF_FFE0);                 // R3 upper B ignored, amt 0
    apply(5'd14, 32'h8000_0000, 32'h0000_003F);                 // R3 amt 31
    apply(5'd15, 32'h8000_0000, 32'h0000_001F);                 // R3 sign fill
    apply(5'd17, 32'h0000_0001, 32'hABCD_EF1F);                 // R3 shl 31
    apply(5'd16, 32'h1234_5678, 32'h0000_0020);                 // R4 amount 0
    apply(5'd16, 32'h0000_0001, 32'd1);                         // R4 wrap
    apply(5'd18, 32'h8000_0000, 32'h7FFF_FFFF);                 // R5 signed min
    apply(5'd19, 32'h8000_0000, 32'h7FFF_FFFF);                 // R5 signed max
    apply(5'd19, 32'hFFFF_FFFF, 32'h0000_0000);                 // R5 -1 vs 0
    apply(5'd23, 32'h0F0F_00FF, 32'h0000_0000);                 // R6 NOT
    notRes = result;
    apply(5'd23, 32'h0F0F_00FF, 32'hDEAD_BEEF);                 // R6 B no effect
    checks++;
    if (result !== notRes) begin
      fails++;
      $display("FAIL R6 NOT depends on B actual=%h expected=%h", result, notRes);
    end
    apply(5'd22, 32'hF0F0_F0F0, 32'hFF00_FF00);                 // R6 XOR
    apply(5'd24, 32'h0000_0000, 32'h0);                         // R7 zero -> 32
    apply(5'd24, 32'h8000_0000, 32'h0);                         // R7 -> 0
    apply(5'd24, 32'h0000_0001, 32'h0);                         // R7 -> 31
    apply(5'd30, 32'hFF80_0110, 32'h0180_FF05);                 // R8 saturate high
    apply(5'd31, 32'h0080_FF10, 32'h0181_0105);                 // R9 clamp at 0
    apply(5'd5, 32'h1234_5678, 32'h1);                          // R10 float range
    apply(5'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);                 // R10, R11
    apply(5'd27, 32'hFFFF_FFFF, 32'hFFFF_FFFF);                 // R10
    apply(5'd30, 32'hFFFF_FFFF, 32'hFFFF_FFFF);                 // R11 no carry on vadd
    for (int i = 0; i < 2000; i++) begin
      apply(5'($urandom), $urandom, $urandom);                  // all opcodes, R11
    end
    done = 1'b1;
    finishUp();
  end
endmodule